// File: doc/BRIEF.md
# Interrupt-on-Change Input Port

This block is a six-pin general-purpose input port that raises a shared change flag when any selected pin differs from a reference copy of the port. The reference is not the previous clock sample: it is refreshed whenever software reads or writes the port. A pin that moves away from the reference therefore keeps the flag raised for as long as it stays different. Software reads the port to accept the new state, and only then does clearing the flag take effect.

Pins pass through a two-stage synchroniser before any use. A small register bus reaches three locations: the port itself, a per-pin change-enable register, and the flag. The flag drives an interrupt request, gated by a global enable input, and a wake request. The wake request ignores the global enable and is active when the flag is up and at least one pin is enabled.

Top module: `ioc_port`

## Requirements
- R1: After synchronous reset the enable register reads 0, the flag reads 0, and irq_o and wake_o are low.
- R2: Address 1 is the change-enable register. A write stores bus_wdata_i[5:0] (bit n enables pin n; 1 = enabled). A read returns those six bits in [5:0], with [7:6] always 0.
- R3: Address 0 reads the synchronised pins in [5:0], with [7:6] equal to 0. A pin change appears in this read value after the second rising clock edge that follows it.
- R4: When an enabled synchronised pin differs from the reference, the flag is 1 from the next edge on. A pin change is therefore visible on the flag after the third edge that follows it.
- R5: A difference on a pin whose enable bit is 0 never sets the flag.
- R6: Any bus read or write at address 0 loads the reference with the current synchronised pins. After that, a flag clear stays cleared while the pins hold.
- R7: A write of 0 to flag bit 0 (address 2) does not clear the flag while an enabled mismatch persists, because the set takes priority.
- R8: Address 2 reads the flag in bit 0, with [7:1] equal to 0. Writing 1 to bit 0 sets the flag and writing 0 clears it (subject to R7). Address 3 reads 0.
- R9: irq_o is high exactly when the flag is 1 and gie_i is high.
- R10: wake_o is high exactly when the flag is 1 and at least one enable bit is 1, whatever the value of gie_i.
- R11: A port access made in the same cycle that a synchronised pin change arrives may or may not set the flag. Either way, no mismatch remains afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 6 | Asynchronous port pins |
| gie_i | input | 1 | Global interrupt enable |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 port, 1 enable, 2 flag, 3 unused |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of a read, 0 otherwise |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
Directed patterns take one pin through each situation in turn: disabled, enabled and newly changed, cleared while it still differs, cleared after a port read, and cleared after a port write. Comparing these cases separates a mismatch against the reference from a mismatch against the previous sample, and shows whether the set or the clear has priority. A single change is timed edge by edge, which exposes a missing or extra synchroniser stage. Seeded random pin vectors, enable masks, global-enable values and bus operations are then checked against a bench model; pins are held stable around bus accesses, so the race of R11 only arises in its own directed case, where either outcome is accepted.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    localparam int PINS_DEF   = 6;
    localparam int DW_DEF     = 8;
    localparam int ADDR_W     = 2;
    localparam int STAGES_DEF = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PORT = 2'd0,
        REG_ENA  = 2'd1,
        REG_FLAG = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic port_acc;   // read or write of the port: refresh reference
        logic ena_wr;
        logic flag_wr;
        logic rd;
        reg_sel_e sel;
    } bus_op_t;

    function automatic bus_op_t decode_op(logic valid, logic we, logic [ADDR_W-1:0] addr);
        bus_op_t op;
        op.sel      = reg_sel_e'(addr);
        op.port_acc = valid && (op.sel == REG_PORT);
        op.ena_wr   = valid && we && (op.sel == REG_ENA);
        op.flag_wr  = valid && we && (op.sel == REG_FLAG);
        op.rd       = valid && !we;
        return op;
    endfunction

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg_q <= '0;
                else     stg_q[0] <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg_q <= '0;
                else     stg_q <= {stg_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect #(
    parameter int PINS = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] sync_i,
    input  logic            port_acc_i,
    input  logic            ena_wr_i,
    input  logic [PINS-1:0] ena_wdata_i,
    output logic [PINS-1:0] ena_o,
    output logic [PINS-1:0] ref_o,
    output logic            mismatch_o
);
    logic [PINS-1:0] ena_q, ref_q, diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= '0;
            ref_q <= '0;
        end else begin
            if (ena_wr_i)   ena_q <= ena_wdata_i;
            if (port_acc_i) ref_q <= sync_i;
        end
    end

    always_comb begin
        diff       = (sync_i ^ ref_q) & ena_q;
        mismatch_o = |diff;
    end

    assign ena_o = ena_q;
    assign ref_o = ref_q;
endmodule

// File: rtl/ioc_flag.sv
module ioc_flag (
    input  logic clk,
    input  logic rst,
    input  logic mismatch_i,
    input  logic flag_wr_i,
    input  logic flag_wdata_i,
    output logic flag_o
);
    logic flag_q;

    // Set by a mismatch outranks any software write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)             flag_q <= 1'b0;
        else if (mismatch_i) flag_q <= 1'b1;
        else if (flag_wr_i)  flag_q <= flag_wdata_i;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/ioc_port.sv
module ioc_port
    import ioc_pkg::*;
#(
    parameter int PINS        = PINS_DEF,
    parameter int DW          = DW_DEF,
    parameter int SYNC_STAGES = STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin_i,
    input  logic              gie_i,
    input  logic              bus_valid_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    // PINS must be smaller than DW.
    bus_op_t         op;
    logic [PINS-1:0] sync_q, en_q, ref_q;
    logic            mismatch, flag_q;
    logic            unused_wdata;

    assign op           = decode_op(bus_valid_i, bus_we_i, bus_addr_i);
    assign unused_wdata = ^bus_wdata_i[DW-1:PINS];

    ioc_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (sync_q)
    );

    ioc_detect #(.PINS(PINS)) u_detect (
        .clk         (clk),
        .rst         (rst),
        .sync_i      (sync_q),
        .port_acc_i  (op.port_acc),
        .ena_wr_i    (op.ena_wr),
        .ena_wdata_i (bus_wdata_i[PINS-1:0]),
        .ena_o       (en_q),
        .ref_o       (ref_q),
        .mismatch_o  (mismatch)
    );

    ioc_flag u_flag (
        .clk          (clk),
        .rst          (rst),
        .mismatch_i   (mismatch),
        .flag_wr_i    (op.flag_wr),
        .flag_wdata_i (bus_wdata_i[0]),
        .flag_o       (flag_q)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (op.rd) begin
            unique case (op.sel)
                REG_PORT: bus_rdata_o[PINS-1:0] = sync_q;
                REG_ENA:  bus_rdata_o[PINS-1:0] = en_q;
                REG_FLAG: bus_rdata_o[0]        = flag_q;
                default:  bus_rdata_o           = '0;
            endcase
        end
    end

    assign irq_o  = flag_q & gie_i;
    assign wake_o = flag_q & (|en_q);
endmodule

// File: rtl/ioc_port_chk.sv
module ioc_port_chk #(
    parameter int PINS = 6,
    parameter int DW   = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            gie,
    input logic            valid,
    input logic            we,
    input logic [1:0]      addr,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic            irq,
    input logic            wake,
    input logic [PINS-1:0] en,
    input logic [PINS-1:0] sync,
    input logic [PINS-1:0] refv,
    input logic            mismatch,
    input logic            flag
);
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flag == 1'b0 && en == '0));

    assert_ena_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (valid && !we && addr == 2'd1) |-> (rdata[DW-1:PINS] == '0));

    assert_mismatch_sets_R4: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> flag);

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !mismatch);

    assert_ref_loaded_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && addr == 2'd0) |=> (refv == $past(sync)));

    assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(mismatch) || $past(valid && we && addr == 2'd2 && wdata[0])));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> gie);

    assert_wake_flag_R10: assert property (@(posedge clk) disable iff (rst)
        wake |-> flag);
endmodule

bind ioc_port ioc_port_chk #(.PINS(PINS), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gie      (gie_i),
    .valid    (bus_valid_i),
    .we       (bus_we_i),
    .addr     (bus_addr_i),
    .wdata    (bus_wdata_i),
    .rdata    (bus_rdata_o),
    .irq      (irq_o),
    .wake     (wake_o),
    .en       (en_q),
    .sync     (sync_q),
    .refv     (ref_q),
    .mismatch (mismatch),
    .flag     (flag_q)
);

// File: tb/tb_ioc_port.sv
module tb_ioc_port;
    localparam int PINS = 6;
    localparam int DW   = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PINS-1:0] pin = '0;
    logic            gie = 1'b0;
    logic            valid = 1'b0;
    logic            we = 1'b0;
    logic [1:0]      addr = 2'd0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq, wake;

    int n_chk  = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;

    always #10 clk = ~clk;

    ioc_port dut (
        .clk (clk), .rst (rst), .pin_i (pin), .gie_i (gie),
        .bus_valid_i (valid), .bus_we_i (we), .bus_addr_i (addr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata),
        .irq_o (irq), .wake_o (wake)
    );

    // Bench model built from the requirements.
    logic [PINS-1:0] m_s1, m_s2, m_ref, m_en;
    logic            m_flag;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_ref <= '0; m_en <= '0; m_flag <= 1'b0;
        end else begin
            m_s1 <= pin;
            m_s2 <= m_s1;
            if (valid && addr == 2'd0) m_ref <= m_s2;
            if (valid && we && addr == 2'd1) m_en <= wdata[PINS-1:0];
            if (|((m_s2 ^ m_ref) & m_en)) m_flag <= 1'b1;
            else if (valid && we && addr == 2'd2) m_flag <= wdata[0];
        end
    end

    function automatic logic [DW-1:0] exp_rdata(logic [1:0] a);
        case (a)
            2'd0:    return {2'b00, m_s2};
            2'd1:    return {2'b00, m_en};
            2'd2:    return {7'd0, m_flag};
            default: return '0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            #5;
            check(irq == (m_flag & gie), "R9 irq", irq, m_flag & gie);
            check(wake == (m_flag & (|m_en)), "R10 wake", wake, m_flag & (|m_en));
            if (valid && !we)
                check(rdata == exp_rdata(addr), "R3/R2/R8 read", rdata, exp_rdata(addr));
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
        valid = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [DW-1:0] d);
        valid = 1'b1; we = 1'b0; addr = a;
        #5 d = rdata;
        @(negedge clk);
        valid = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd20240611));
        cyc(3);
        rst = 1'b0;
        gie = 1'b1;
        cyc(1);

        // R1 reset state
        bus_rd(2'd1, d); check(d == 8'h00, "R1 enable", d, 8'h00);
        bus_rd(2'd2, d); check(d == 8'h00, "R1 flag", d, 8'h00);
        #1 check(irq == 1'b0 && wake == 1'b0, "R1 irq/wake", {irq, wake}, 0);

        // R2 enable register, upper bits read 0
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, d); check(d == 8'h3F, "R2 enable readback", d, 8'h3F);
        bus_wr(2'd1, 8'h00);

        // R3 two-edge synchroniser latency on the port read
        pin = 6'h2A; valid = 1'b1; we = 1'b0; addr = 2'd0;
        @(negedge clk); #5 check(rdata == 8'h00, "R3 after one edge", rdata, 8'h00);
        @(negedge clk); #5 check(rdata == 8'h2A, "R3 after two edges", rdata, 8'h2A);
        @(negedge clk); valid = 1'b0;

        // R5 disabled pin ignored
        bus_wr(2'd1, 8'h01);
        pin = 6'h0A;
        cyc(5);
        bus_rd(2'd2, d); check(d == 8'h00, "R5 disabled pin flag", d, 8'h00);
        #1 check(wake == 1'b0, "R5 wake", wake, 0);

        // R4 enabled pin: flag after third edge
        pin = 6'h0B;
        @(negedge clk); #1 check(wake == 1'b0, "R4 edge1", wake, 0);
        @(negedge clk); #1 check(wake == 1'b0, "R4 edge2", wake, 0);
        @(negedge clk); #1 check(wake == 1'b1, "R4 edge3", wake, 1);
        check(irq == 1'b1, "R9 irq with gie", irq, 1);
        gie = 1'b0;
        #1 check(irq == 1'b0, "R9 irq gated", irq, 0);
        check(wake == 1'b1, "R10 wake without gie", wake, 1);
        gie = 1'b1;
        @(negedge clk);

        // R7 clear loses to persisting mismatch
        bus_wr(2'd2, 8'h00);
        bus_rd(2'd2, d); check(d == 8'h01, "R7 clear ignored", d, 8'h01);

        // R6 port read refreshes reference, clear sticks
        bus_rd(2'd0, d);
        bus_wr(2'd2, 8'h00);
        cyc(3);
        bus_rd(2'd2, d); check(d == 8'h00, "R6 clear after read", d, 8'h00);

        // R6 port write refreshes reference too
        pin = 6'h0A;
        cyc(4);
        bus_rd(2'd2, d); check(d == 8'h01, "R4 second change", d, 8'h01);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd2, 8'h00);
        cyc(2);
        bus_rd(2'd2, d); check(d == 8'h00, "R6 clear after write", d, 8'h00);

        // R8 software set and clear, R10 needs an enable
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd2, d); check(d == 8'h01, "R8 set readback", d, 8'h01);
        #1 check(wake == 1'b0, "R10 wake no enable", wake, 0);
        check(irq == 1'b1, "R9 irq on soft set", irq, 1);
        bus_wr(2'd2, 8'h00);
        bus_rd(2'd2, d); check(d == 8'h00, "R8 clear", d, 8'h00);
        bus_rd(2'd3, d); check(d == 8'h00, "R8 unused address", d, 8'h00);

        // R11 race: port read in the cycle the synchronised change arrives
        bus_wr(2'd1, 8'h3F);
        bus_rd(2'd0, d);
        pin = 6'h15;
        cyc(2);
        bus_rd(2'd0, d); check(d == 8'h15, "R11 port value at race", d, 8'h15);
        bus_wr(2'd2, 8'h00);
        cyc(3);
        bus_rd(2'd2, d); check(d == 8'h00, "R11 no lingering mismatch", d, 8'h00);

        // Random phase against the model
        mon_on = 1'b1;
        for (int it = 0; it < 400; it++) begin
            pin = PINS'($urandom);
            gie = 1'($urandom);
            cyc(4);
            for (int k = 0; k < 1 + int'($urandom % 3); k++) begin
                if (($urandom % 2) == 0) bus_wr(2'($urandom), DW'($urandom));
                else                     bus_rd(2'($urandom), d);
            end
            cyc(1);
        end
        mon_on = 1'b0;

        summary();
        $finish;
    end
endmodule